// File: doc/BRIEF.md
# Time-aligned sync pulse generator

This block drives a single sync output that fires when an externally supplied nanosecond time value reaches a programmed target. One clock cycle of the block is one 8 ns tick, so the pulse width and the repeat period are both counted in 8 ns units. A one-shot fire suits a once-per-second marker: software loads the next whole second as the target, arms the block, and the pulse appears on the first cycle the running time is at or past that value.

Width and period are written through three packed 16-bit timing words. The 48-bit target is written into a shadow copy and only becomes live on a frame-sync strobe that carries both the load-select and the init qualifier. Arming takes a fresh rising edge on an enable input: holding an enable high never re-arms the block after it has fired. With the periodic enable set, the block keeps firing every period after the first match. Dropping both enables stops everything at once.

Top module: `sync_pulse_gen`

## Requirements
- R1: After reset `sync_pulse` and `armed` are low, all timing words and the live target are zero, and `cfg_bad` is therefore high.
- R2: Writes at address 1 and 2 set the pulse width as {word2[6:0], word1[15:14]} (9 bits); writes at address 0 and 1 set the period as {word1[13:0], word0[15:0]} (30 bits). The pulse stays high for exactly width cycles.
- R3: Bits 15:7 of the word at address 2 have no effect on the width or the period.
- R4: Addresses 3, 4 and 5 write target shadow bits 15:0, 31:16 and 47:32, with target bits 3:0 forced to zero; the live target takes the shadow only on a cycle where `frame_sync`, `load_sel` and `init_en` are all high, and holds otherwise.
- R5: A 0-to-1 change on `oneshot_en` or `periodic_en` arms the block; an enable that stays high does not arm it again.
- R6: While armed with a valid configuration, the pulse rises on the clock edge of the first cycle where `now_ns` is at or past the live target.
- R7: With `periodic_en` low, firing clears `armed`.
- R8: With `periodic_en` high at the first fire, the pulse repeats every period cycles while `periodic_en` stays high, and `armed` stays high.
- R9: A cycle with both enables low clears `sync_pulse` and `armed` on the next edge, cutting short any pulse in progress.
- R10: `cfg_bad` is high when the width is zero or larger than the period (width equal to period is valid); an arming edge while `cfg_bad` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per 8 ns tick |
| rst_n | input | 1 | Active-low synchronous reset |
| now_ns | input | 48 | Current time in nanoseconds |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0..2 timing words, 3..5 target shadow |
| wr_data | input | 16 | Register write data |
| load_sel | input | 1 | Qualifier: allow target transfer on frame sync |
| init_en | input | 1 | Qualifier: init, also required for target transfer |
| frame_sync | input | 1 | Frame-sync strobe that commits the target shadow |
| oneshot_en | input | 1 | One-shot enable, armed on its rising edge |
| periodic_en | input | 1 | Periodic enable, armed on its rising edge |
| sync_pulse | output | 1 | Sync output pulse |
| armed | output | 1 | Block is waiting for, or repeating, a fire |
| cfg_bad | output | 1 | Width/period combination is invalid |

## Verification
The in-module properties watch, on every cycle, that a rising pulse was preceded by an armed state, that both enables low clears the output and the arm, that a bad configuration never arms, that the live target only moves on a qualified frame sync, and that a non-periodic fire disarms. What they cannot show is the exact moment and length of each pulse: the bench's scenarios establish the rise cycle against the committed target, the width decoded from the odd field split with junk in the upper bits of the third word, the periodic spacing, the truncation of a pulse on stop, and that a held enable never fires twice.

// File: rtl/sync_pulse_gen.sv
module sync_pulse_gen (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [47:0] now_ns,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic        load_sel,
  input  logic        init_en,
  input  logic        frame_sync,
  input  logic        oneshot_en,
  input  logic        periodic_en,
  output logic        sync_pulse,
  output logic        armed,
  output logic        cfg_bad
);
  localparam int TIME_W = 48;
  localparam int WID_W  = 9;
  localparam int PER_W  = 30;
  localparam int LO_W   = WID_W - 7;

  logic [15:0]       w0_q, w1_q;
  logic [6:0]        w2_q;
  logic [15:4]       sh0_q;
  logic [15:0]       sh1_q, sh2_q;
  logic [TIME_W-1:0] tgt_q;
  logic [WID_W-1:0]  width_w, cnt_q;
  logic [PER_W-1:0]  period_w, pcnt_q;
  logic os_q, pe_q, run_q, pulse_q, armed_q;
  logic arm_edge, fire_cmp, fire_per, fire, stop, commit;

  assign width_w  = {w2_q, w1_q[15:14]};
  assign period_w = {w1_q[13:0], w0_q};
  assign cfg_bad  = (width_w == '0) || (PER_W'(width_w) > period_w);
  assign arm_edge = (oneshot_en & ~os_q) | (periodic_en & ~pe_q);
  assign stop     = ~oneshot_en & ~periodic_en;
  assign fire_cmp = armed_q & ~run_q & ~cfg_bad & (now_ns >= tgt_q);
  assign fire_per = run_q & periodic_en & (pcnt_q == '0);
  assign fire     = fire_cmp | fire_per;
  assign commit   = frame_sync & load_sel & init_en;
  assign sync_pulse = pulse_q;
  assign armed      = armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w0_q <= '0; w1_q <= '0; w2_q <= '0;
      sh0_q <= '0; sh1_q <= '0; sh2_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        3'd0: w0_q  <= wr_data;
        3'd1: w1_q  <= wr_data;
        3'd2: w2_q  <= wr_data[6:0];
        3'd3: sh0_q <= wr_data[15:4];
        3'd4: sh1_q <= wr_data;
        3'd5: sh2_q <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      tgt_q <= '0;
    else if (commit) tgt_q <= {sh2_q, sh1_q, sh0_q, 4'b0000};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      os_q <= 1'b0; pe_q <= 1'b0;
    end else begin
      os_q <= oneshot_en; pe_q <= periodic_en;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || stop) begin
      pulse_q <= 1'b0; armed_q <= 1'b0; run_q <= 1'b0;
      cnt_q <= '0; pcnt_q <= '0;
    end else if (fire) begin
      pulse_q <= 1'b1;
      cnt_q   <= width_w - 1'b1;
      pcnt_q  <= period_w - 1'b1;
      run_q   <= periodic_en;
      armed_q <= periodic_en;
    end else begin
      if (pulse_q) begin
        if (cnt_q == '0) pulse_q <= 1'b0;
        else             cnt_q   <= cnt_q - 1'b1;
      end
      if (run_q) begin
        if (!periodic_en) begin
          run_q <= 1'b0; armed_q <= 1'b0;
        end else pcnt_q <= pcnt_q - 1'b1;
      end else if (!armed_q && arm_edge && !cfg_bad) armed_q <= 1'b1;
    end
  end

  p_rise_needs_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_pulse) |-> $past(armed));
  p_stop_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!oneshot_en && !periodic_en) |=> (!sync_pulse && !armed));
  p_bad_never_arms_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_bad && !armed) |=> !armed);
  p_target_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_sync && load_sel && init_en) |=> $stable(tgt_q));
  p_oneshot_disarms_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !periodic_en && !cfg_bad && (now_ns >= tgt_q)) |=> !armed);
  p_periodic_keeps_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_pulse && armed && periodic_en && oneshot_en) |=> armed);
endmodule

// File: tb/sync_pulse_gen_tb.sv
`timescale 1ns/1ps
module sync_pulse_gen_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, load_sel = 1'b0, init_en = 1'b0, frame_sync = 1'b0;
  logic oneshot_en = 1'b0, periodic_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [47:0] now_ns;
  logic sync_pulse, armed, cfg_bad;
  int cyc = 0, checks = 0, failures = 0;
  int exp_rise[$], exp_wid[$];
  string exp_tag[$];
  bit prev_p = 1'b0;
  int rise_c = 0, hi_n = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign now_ns = 48'(cyc) * 48'd8;

  sync_pulse_gen u_dut (.clk(clk), .rst_n(rst_n), .now_ns(now_ns), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .load_sel(load_sel), .init_en(init_en),
    .frame_sync(frame_sync), .oneshot_en(oneshot_en), .periodic_en(periodic_en),
    .sync_pulse(sync_pulse), .armed(armed), .cfg_bad(cfg_bad));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic fsync(input logic ls, input logic ini);
    @(negedge clk); frame_sync = 1'b1; load_sel = ls; init_en = ini;
    @(negedge clk); frame_sync = 1'b0; load_sel = 1'b0; init_en = 1'b0;
  endtask

  task automatic push(input int r, input int w, input string t);
    exp_rise.push_back(r); exp_wid.push_back(w); exp_tag.push_back(t);
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // Monitor: measures each pulse and pops the expected item
  always @(negedge clk) begin
    if (rst_n) begin
      if (sync_pulse && !prev_p) begin rise_c = cyc; hi_n = 0; end
      if (sync_pulse) hi_n++;
      if (!sync_pulse && prev_p) begin
        if (exp_rise.size() == 0) chk(1'b0, "R5 unexpected pulse", rise_c, -1);
        else begin
          int er, ew; string et;
          er = exp_rise.pop_front(); ew = exp_wid.pop_front(); et = exp_tag.pop_front();
          chk(rise_c == er, {et, " rise cycle"}, rise_c, er);
          chk(hi_n == ew, {et, " width R2"}, hi_n, ew);
        end
      end
      prev_p = sync_pulse;
    end
  end

  initial begin
    #(20 * 150000);
    chk(1'b0, "watchdog", cyc, -1);
    summary();
  end

  initial begin
    int a, cf, tgt;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sync_pulse == 1'b0, "R1 pulse", sync_pulse, 0);
    chk(armed == 1'b0, "R1 armed", armed, 0);
    chk(cfg_bad == 1'b1, "R1 cfg_bad", cfg_bad, 1);

    // width = {1, 01} = 5, period = 65536
    wr(3'd0, 16'h0000); wr(3'd1, 16'h4001); wr(3'd2, 16'h0001);
    chk(cfg_bad == 1'b0, "R2 valid cfg", cfg_bad, 0);
    // target 0x032F -> 800 after low nibble forced to zero (R4)
    wr(3'd3, 16'h032F); wr(3'd4, 16'h0000); wr(3'd5, 16'h0000);
    fsync(1'b1, 1'b1);
    wr(3'd3, 16'h0190);
    fsync(1'b1, 1'b0);
    fsync(1'b0, 1'b1);
    @(negedge clk); a = cyc; oneshot_en = 1'b1;
    cf = (a + 1 > 100) ? a + 1 : 100;
    push(cf + 1, 5, "R4 R6 one-shot target");
    @(negedge clk); @(negedge clk);
    chk(armed == 1'b1, "R5 armed after edge", armed, 1);
    wait_cyc(cf + 10);
    chk(armed == 1'b0, "R7 disarmed after fire", armed, 0);
    wait_cyc(cf + 60);
    oneshot_en = 1'b0;
    @(negedge clk);

    // width {3, 11} = 15, junk in word2[15:7] (R3)
    wr(3'd1, 16'hC001); wr(3'd2, 16'hFE83);
    @(negedge clk); a = cyc; oneshot_en = 1'b1;
    push(a + 2, 15, "R3 R6 past target");
    wait_cyc(a + 30);
    oneshot_en = 1'b0;
    @(negedge clk);

    // periodic: period 20, width 5
    wr(3'd0, 16'd20); wr(3'd1, 16'h4000); wr(3'd2, 16'h0001);
    tgt = ((cyc + 30) / 2 + 1) * 16;
    wr(3'd3, tgt[15:0]); wr(3'd4, tgt[31:16]); wr(3'd5, 16'h0000);
    fsync(1'b1, 1'b1);
    @(negedge clk); a = cyc; periodic_en = 1'b1;
    cf = (a + 1 > tgt / 8) ? a + 1 : tgt / 8;
    for (int n = 0; n < 3; n++) push(cf + 1 + n * 20, 5, "R8 periodic");
    push(cf + 61, 3, "R9 truncated");
    wait_cyc(cf + 50);
    chk(armed == 1'b1, "R8 stays armed", armed, 1);
    wait_cyc(cf + 63);
    periodic_en = 1'b0;
    @(negedge clk);
    chk(sync_pulse == 1'b0, "R9 pulse cut", sync_pulse, 0);
    chk(armed == 1'b0, "R9 disarmed", armed, 0);

    // invalid configurations (R10)
    wr(3'd2, 16'h0000); wr(3'd1, 16'h0000);
    chk(cfg_bad == 1'b1, "R10 zero width", cfg_bad, 1);
    @(negedge clk); oneshot_en = 1'b1;
    repeat (3) @(negedge clk);
    chk(armed == 1'b0, "R10 arm ignored", armed, 0);
    oneshot_en = 1'b0;
    wr(3'd0, 16'd4); wr(3'd1, 16'h4000); wr(3'd2, 16'h0001);
    chk(cfg_bad == 1'b1, "R10 width over period", cfg_bad, 1);
    wr(3'd0, 16'd5);
    chk(cfg_bad == 1'b0, "R10 width equal period", cfg_bad, 0);

    repeat (10) @(negedge clk);
    chk(exp_rise.size() == 0, "R6 all pulses seen", exp_rise.size(), 0);
    summary();
  end
endmodule